// File: doc/BRIEF.md
# Half-Duplex Debug Data Mailbox

This block is a small mailbox that carries data between a processor core and an external debugger. It keeps one 32-bit holding word for each direction. The receive word carries data from the debugger to the core, and the transmit word carries data from the core to the debugger. Each direction has its own full flag. The debugger side has a plain 32-bit write port for the receive word and a 32-bit read port for the transmit word. Both full flags are driven out as status.

The core side is one 64-bit system-register port that moves data in both directions in a single access. The block decodes the register encoding presented with each access. On a write, the upper half goes to the receive word and the lower half goes to the transmit word. On a read, the halves are swapped: the transmit word comes back in the upper half and the receive word in the lower half. The flag side effects are different for each half.

Read data is combinational, in the cycle of the request. Flag and holding-word updates take effect on the next rising clock edge.

Top module: `dbg_mailbox`

## Requirements
- R1: Reset clears both holding words and both full flags. After reset, `dbg_rx_full`=0, `dbg_tx_full`=0 and `dbg_tx_rdata`=0.
- R2: A decoded core write loads `core_wdata[63:32]` into the receive word and leaves `dbg_rx_full` unchanged.
- R3: A decoded core write loads `core_wdata[31:0]` into the transmit word and sets `dbg_tx_full` to 1 on the next edge.
- R4: A decoded core read with `dbg_rx_full`=1 returns the transmit word on `core_rdata[63:32]` and the receive word on `core_rdata[31:0]`, in the same cycle.
- R5: A decoded core read with `dbg_rx_full`=0 returns all zeros on `core_rdata`.
- R6: Every decoded core read clears `dbg_rx_full` to 0 on the next edge.
- R7: A core access is decoded only when its fields are op0=2'b10, op1=3'b011, CRn=4'b0000, CRm=4'b0100 and op2=3'b000. Any other encoding leaves both words and both flags unchanged, and `core_rdata` reads zero.
- R8: A debugger write (`dbg_rx_we`=1) loads `dbg_rx_wdata` into the receive word and sets `dbg_rx_full`.
- R9: `dbg_tx_rdata` always shows the transmit word. A debugger read (`dbg_tx_re`=1) clears `dbg_tx_full` on the next edge.
- R10: When the core and the debugger act on the same flag in one cycle, the core wins. A core read together with a debugger write leaves `dbg_rx_full`=0. A core write together with a debugger read leaves `dbg_tx_full`=1.
- R11: A core write and a debugger write in the same cycle leave the core's upper half in the receive word, and `dbg_rx_full` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core system-register access strobe |
| core_we | input | 1 | 1 = core write, 0 = core read |
| core_op0 | input | 2 | Encoding field op0 |
| core_op1 | input | 3 | Encoding field op1 |
| core_crn | input | 4 | Encoding field CRn |
| core_crm | input | 4 | Encoding field CRm |
| core_op2 | input | 3 | Encoding field op2 |
| core_wdata | input | 64 | Core write data |
| core_rdata | output | 64 | Core read data (combinational) |
| core_hit | output | 1 | The current access decodes to this register |
| dbg_rx_we | input | 1 | Debugger write strobe for the receive word |
| dbg_rx_wdata | input | 32 | Debugger write data |
| dbg_tx_re | input | 1 | Debugger read strobe for the transmit word |
| dbg_tx_rdata | output | 32 | Transmit word |
| dbg_rx_full | output | 1 | Receive word holds unread data |
| dbg_tx_full | output | 1 | Transmit word holds unread data |

## Verification
The bench checks the word swap by writing distinct patterns into the two halves. A design that skipped the swap would return the halves in write order. It reads with the receive flag clear and checks for zeros, which catches a design that leaks stale words. It also checks that a core write keeps the receive flag as it was in both states, which catches a design that sets or clears it. It sends near-miss encodings and then reads the words back through the debugger and core ports, which exposes a loose decoder. Same-cycle collisions on each flag expose a design that lets the debugger override the core.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;

   // Fields of a system-register access encoding
   typedef struct packed {
      logic [1:0] op0;
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } sysreg_enc_t;

   // Encoding selecting the mailbox register (R7)
   localparam sysreg_enc_t MBOX_ENC = '{op0: 2'b10, op1: 3'b011,
                                        crn: 4'b0000, crm: 4'b0100,
                                        op2: 3'b000};

endpackage

// File: rtl/dbg_mailbox_decode.sv
module dbg_mailbox_decode
   import dbg_mailbox_pkg::*;
#(
   parameter sysreg_enc_t MATCH = MBOX_ENC
) (
   input  logic        req_i,
   input  logic        we_i,
   input  sysreg_enc_t enc_i,
   output logic        hit_o,
   output logic        rd_hit_o,
   output logic        wr_hit_o
);

   // R7: exact match on every field
   always_comb begin
      hit_o    = req_i && (enc_i == MATCH);
      rd_hit_o = hit_o && !we_i;
      wr_hit_o = hit_o &&  we_i;
   end

endmodule

// File: rtl/dbg_mailbox_chan.sv
// One direction of the mailbox: holding word plus full flag.
// The primary load port wins over the secondary one.
// CLR_WINS picks which flag request wins a same-cycle clash.
module dbg_mailbox_chan #(
   parameter int unsigned WORD_W   = 32,
   parameter bit          CLR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_pri_i,
   input  logic [WORD_W-1:0] d_pri_i,
   input  logic              ld_sec_i,
   input  logic [WORD_W-1:0] d_sec_i,
   input  logic              set_i,
   input  logic              clr_i,
   output logic [WORD_W-1:0] data_o,
   output logic              full_o
);

   logic full_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n)        data_o <= '0;
      else if (ld_pri_i) data_o <= d_pri_i;
      else if (ld_sec_i) data_o <= d_sec_i;
   end

   generate
      if (CLR_WINS) begin : g_clr_wins
         always_comb begin
            if (clr_i)      full_nxt = 1'b0;
            else if (set_i) full_nxt = 1'b1;
            else            full_nxt = full_o;
         end
      end else begin : g_set_wins
         always_comb begin
            if (set_i)      full_nxt = 1'b1;
            else if (clr_i) full_nxt = 1'b0;
            else            full_nxt = full_o;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) full_o <= 1'b0;
      else        full_o <= full_nxt;
   end

   // R1: flag clear one edge after reset
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> !full_o && (data_o == '0));

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
   import dbg_mailbox_pkg::*;
#(
   parameter int unsigned WORD_W          = 32,
   parameter bit          ZERO_WHEN_EMPTY = 1'b1,
   localparam int unsigned REG_W          = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [1:0]        core_op0,
   input  logic [2:0]        core_op1,
   input  logic [3:0]        core_crn,
   input  logic [3:0]        core_crm,
   input  logic [2:0]        core_op2,
   input  logic [REG_W-1:0]  core_wdata,
   output logic [REG_W-1:0]  core_rdata,
   output logic              core_hit,
   input  logic              dbg_rx_we,
   input  logic [WORD_W-1:0] dbg_rx_wdata,
   input  logic              dbg_tx_re,
   output logic [WORD_W-1:0] dbg_tx_rdata,
   output logic              dbg_rx_full,
   output logic              dbg_tx_full
);

   generate
      if (WORD_W == 0 || (WORD_W % 8) != 0) begin : g_bad_width
         $error("dbg_mailbox: WORD_W must be a non-zero multiple of 8");
      end
   endgenerate

   sysreg_enc_t       enc;
   logic              rd_hit, wr_hit;
   logic [WORD_W-1:0] rx_word, tx_word;
   logic [WORD_W-1:0] wr_hi, wr_lo;

   assign enc   = '{op0: core_op0, op1: core_op1, crn: core_crn,
                    crm: core_crm, op2: core_op2};
   assign wr_hi = core_wdata[REG_W-1:WORD_W];
   assign wr_lo = core_wdata[WORD_W-1:0];

   dbg_mailbox_decode #(.MATCH(MBOX_ENC)) u_dec (
      .req_i    (core_req),
      .we_i     (core_we),
      .enc_i    (enc),
      .hit_o    (core_hit),
      .rd_hit_o (rd_hit),
      .wr_hit_o (wr_hit)
   );

   // Receive direction: core write has priority on data (R11),
   // core read clear beats debugger set (R10).
   dbg_mailbox_chan #(.WORD_W(WORD_W), .CLR_WINS(1'b1)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_pri_i (wr_hit),
      .d_pri_i  (wr_hi),
      .ld_sec_i (dbg_rx_we),
      .d_sec_i  (dbg_rx_wdata),
      .set_i    (dbg_rx_we),
      .clr_i    (rd_hit),
      .data_o   (rx_word),
      .full_o   (dbg_rx_full)
   );

   // Transmit direction: core write set beats debugger read clear (R10)
   dbg_mailbox_chan #(.WORD_W(WORD_W), .CLR_WINS(1'b0)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_pri_i (wr_hit),
      .d_pri_i  (wr_lo),
      .ld_sec_i (1'b0),
      .d_sec_i  ('0),
      .set_i    (wr_hit),
      .clr_i    (dbg_tx_re),
      .data_o   (tx_word),
      .full_o   (dbg_tx_full)
   );

   assign dbg_tx_rdata = tx_word;

   // Core read: word-swapped halves (R4)
   generate
      if (ZERO_WHEN_EMPTY) begin : g_rd_zero
         assign core_rdata = (rd_hit && dbg_rx_full) ? {tx_word, rx_word} : '0;

         // R5: empty receive flag reads as zero
         p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (core_req && !core_we && !dbg_rx_full) |-> (core_rdata == '0));
      end else begin : g_rd_raw
         assign core_rdata = rd_hit ? {tx_word, rx_word} : '0;
      end
   endgenerate

   // R2: core write keeps the receive flag when the debugger is idle
   p_wr_keep_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !dbg_rx_we) |=> (dbg_rx_full == $past(dbg_rx_full)));

   // R3: core write sets the transmit flag
   p_wr_sets_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> dbg_tx_full);

   // R6: core read clears the receive flag
   p_rd_clears_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> !dbg_rx_full);

   // R7: an unmatched access with an idle debugger changes nothing
   p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && !core_hit && !dbg_rx_we && !dbg_tx_re) |=>
         ($stable(dbg_rx_full) && $stable(dbg_tx_full) && $stable(dbg_tx_rdata)));

   // R8: debugger write sets the receive flag unless the core reads
   p_dbg_wr_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_rx_we && !rd_hit) |=> dbg_rx_full);

   // R9: debugger read clears the transmit flag unless the core writes
   p_dbg_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_tx_re && !wr_hit) |=> !dbg_tx_full);

endmodule

// File: tb/dbg_mailbox_bench.sv
`timescale 1ns/1ps
module dbg_mailbox_bench;

   localparam realtime HALF = 2.5;

   localparam logic [2:0] K_CW  = 3'd0; // core write, matching encoding
   localparam logic [2:0] K_CR  = 3'd1; // core read, matching encoding
   localparam logic [2:0] K_DW  = 3'd2; // debugger write
   localparam logic [2:0] K_DR  = 3'd3; // debugger read
   localparam logic [2:0] K_CM  = 3'd4; // core write, CRm off by one
   localparam logic [2:0] K_CRM = 3'd5; // core read, CRm off by one

   typedef struct packed {
      logic [2:0]  kind;
      logic [63:0] data;
      logic        chk_rd;
      logic [63:0] exp_rd;
      logic        exp_rxf;
      logic        exp_txf;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{K_CR,  64'h0,                   1'b1, 64'h0,                   1'b0, 1'b0, 8'd5},  // R5
      '{K_CW,  64'hAAAA0001_BBBB0002,   1'b0, 64'h0,                   1'b0, 1'b1, 8'd3},  // R2 R3
      '{K_CR,  64'h0,                   1'b1, 64'h0,                   1'b0, 1'b1, 8'd5},  // R5
      '{K_DW,  64'h12345678,            1'b0, 64'h0,                   1'b1, 1'b1, 8'd8},  // R8
      '{K_CR,  64'h0,                   1'b1, 64'hBBBB0002_12345678,   1'b0, 1'b1, 8'd4},  // R4 R6
      '{K_DR,  64'h0,                   1'b1, 64'h00000000_BBBB0002,   1'b0, 1'b0, 8'd9},  // R9
      '{K_DW,  64'hCAFE0000,            1'b0, 64'h0,                   1'b1, 1'b0, 8'd8},  // R8
      '{K_CW,  64'h00000011_00000022,   1'b0, 64'h0,                   1'b1, 1'b1, 8'd2},  // R2
      '{K_CR,  64'h0,                   1'b1, 64'h00000022_00000011,   1'b0, 1'b1, 8'd4},  // R4
      '{K_CM,  64'hFFFFFFFF_FFFFFFFF,   1'b1, 64'h0,                   1'b0, 1'b1, 8'd7},  // R7
      '{K_DR,  64'h0,                   1'b1, 64'h00000000_00000022,   1'b0, 1'b0, 8'd7},  // R7
      '{K_DW,  64'h00000055,            1'b0, 64'h0,                   1'b1, 1'b0, 8'd8},  // R8
      '{K_CRM, 64'h0,                   1'b1, 64'h0,                   1'b1, 1'b0, 8'd7},  // R7
      '{K_CR,  64'h0,                   1'b1, 64'h00000022_00000055,   1'b0, 1'b0, 8'd4}   // R4
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        core_req, core_we;
   logic [1:0]  core_op0;
   logic [2:0]  core_op1;
   logic [3:0]  core_crn, core_crm;
   logic [2:0]  core_op2;
   logic [63:0] core_wdata, core_rdata;
   logic        core_hit;
   logic        dbg_rx_we, dbg_tx_re;
   logic [31:0] dbg_rx_wdata, dbg_tx_rdata;
   logic        dbg_rx_full, dbg_tx_full;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(HALF) clk = ~clk;

   dbg_mailbox u_dbg_mailbox (
      .clk, .rst_n, .core_req, .core_we, .core_op0, .core_op1, .core_crn,
      .core_crm, .core_op2, .core_wdata, .core_rdata, .core_hit,
      .dbg_rx_we, .dbg_rx_wdata, .dbg_tx_re, .dbg_tx_rdata,
      .dbg_rx_full, .dbg_tx_full
   );

   task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic idle();
      core_req = 1'b0; core_we = 1'b0; core_wdata = '0;
      core_op0 = 2'b10; core_op1 = 3'b011; core_crn = 4'b0000;
      core_crm = 4'b0100; core_op2 = 3'b000;
      dbg_rx_we = 1'b0; dbg_rx_wdata = '0; dbg_tx_re = 1'b0;
   endtask

   task automatic core_drive(input logic we, input logic miss, input logic [63:0] d);
      core_req = 1'b1; core_we = we; core_wdata = d;
      core_crm = miss ? 4'b0101 : 4'b0100;
   endtask

   // Drive at falling edge, sample comb, cross rising edge, sample flags
   logic [63:0] comb_rd;
   task automatic cycle_end();
      @(posedge clk); #1;
      idle();
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 rx_full after reset", 64'(dbg_rx_full), 64'd0);
      check("R1 tx_full after reset", 64'(dbg_tx_full), 64'd0);
      check("R1 tx word after reset", 64'(dbg_tx_rdata), 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // Vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         case (VEC[i].kind)
            K_CW:    core_drive(1'b1, 1'b0, VEC[i].data);
            K_CR:    core_drive(1'b0, 1'b0, VEC[i].data);
            K_CM:    core_drive(1'b1, 1'b1, VEC[i].data);
            K_CRM:   core_drive(1'b0, 1'b1, VEC[i].data);
            K_DW:    begin dbg_rx_we = 1'b1; dbg_rx_wdata = VEC[i].data[31:0]; end
            default: dbg_tx_re = 1'b1;
         endcase
         #1;
         comb_rd = (VEC[i].kind == K_DR) ? {32'h0, dbg_tx_rdata} : core_rdata;
         if (VEC[i].chk_rd)
            check($sformatf("R%0d vector %0d read data", VEC[i].req, i), comb_rd, VEC[i].exp_rd);
         cycle_end();
         check($sformatf("R%0d vector %0d rx_full", VEC[i].req, i), 64'(dbg_rx_full), 64'(VEC[i].exp_rxf));
         check($sformatf("R%0d vector %0d tx_full", VEC[i].req, i), 64'(dbg_tx_full), 64'(VEC[i].exp_txf));
      end

      // R10: core read and debugger write in one cycle, core clear wins
      @(negedge clk); dbg_rx_we = 1'b1; dbg_rx_wdata = 32'h0000_0077; cycle_end();
      @(negedge clk); core_drive(1'b0, 1'b0, '0);
      dbg_rx_we = 1'b1; dbg_rx_wdata = 32'h0000_0088; #1;
      check("R10 read during debugger write", core_rdata, 64'h00000022_00000077);
      cycle_end();
      check("R10 rx_full core read wins", 64'(dbg_rx_full), 64'd0);

      // R10: core write and debugger read in one cycle, core set wins
      @(negedge clk); core_drive(1'b1, 1'b0, 64'h00000099_00000044); dbg_tx_re = 1'b1; cycle_end();
      check("R10 tx_full core write wins", 64'(dbg_tx_full), 64'd1);
      check("R10 tx word loaded", 64'(dbg_tx_rdata), 64'h44);

      // R11: core write and debugger write collide on the receive word
      @(negedge clk); core_drive(1'b1, 1'b0, 64'h0000ABCD_00000066);
      dbg_rx_we = 1'b1; dbg_rx_wdata = 32'h1111_2222; cycle_end();
      check("R11 rx_full set", 64'(dbg_rx_full), 64'd1);
      @(negedge clk); core_drive(1'b0, 1'b0, '0); #1;
      check("R11 core data wins", core_rdata, 64'h00000066_0000ABCD);
      cycle_end();

      // R1: reset after activity
      @(negedge clk); dbg_rx_we = 1'b1; dbg_rx_wdata = 32'h5; cycle_end();
      @(negedge clk); rst_n = 1'b0; cycle_end();
      check("R1 rx_full after mid reset", 64'(dbg_rx_full), 64'd0);
      check("R1 tx_full after mid reset", 64'(dbg_tx_full), 64'd0);
      check("R1 tx word after mid reset", 64'(dbg_tx_rdata), 64'd0);
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(HALF * 2 * 20000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule